// File: doc/BRIEF.md
# Byte-Lane Field Inverse and Bit-Matrix Unit

This unit works on a 128-bit vector of sixteen bytes in parallel. Each byte takes three steps in a fixed order. First, if enabled, the byte is replaced by its multiplicative inverse in the binary field of 256 elements, reduced by x^8 + x^4 + x^3 + x + 1. Second, the byte is multiplied by an 8x8 bit matrix, so each result bit is the parity of a masked selection of the byte's bits. Third, the byte is XORed with an 8-bit constant.

A second 128-bit operand carries two 64-bit matrices. Each matrix serves one group of eight bytes. With the identity matrix and a zero constant, the unit returns the plain field inverse. Other matrices can permute, reverse, rotate or mix the bits of every byte.

The inverse is computed combinationally as x^254 through a chain of squarings and multiplies. The result is captured in an output register one cycle after the operation is presented.

Top module: `gf8_affine_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` equals the `in_valid` value sampled at the previous rising edge.
- R3: Each result byte is M·v XOR `in_imm`, where v is the inverse of the input byte when `in_inv_en` = 1 and the input byte itself when `in_inv_en` = 0.
- R4: The inversion uses the field polynomial 0x11B, so inv(x)·x = 1 for every nonzero x.
- R5: The inverse of 0 is 0. A zero byte with inversion enabled therefore yields `in_imm`.
- R6: Result bit i of a byte is the XOR of the input bits selected by mask byte (7 − i) of its 64-bit matrix. Mask byte m occupies matrix bits [8m+7:8m], and mask bit j selects input bit j.
- R7: Byte lane k occupies bits [8k+7:8k] of the data and the result. Lanes 0–7 use `in_mat[63:0]` and lanes 8–15 use `in_mat[127:64]`.
- R8: The matrix 64'h0102040810204080 with a zero constant passes each byte through unchanged, or returns its inverse when inversion is enabled.
- R9: When `in_valid` is low, `out_data` keeps its previous value, and changes on the data inputs do not reach it.
- R10: The matrix 64'h8040201008040201 reverses the bit order of each byte. A matrix whose mask byte (7 − i) selects bit (i − 1) mod 8 rotates each byte left by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_data | input | 128 | Sixteen source bytes |
| in_mat | input | 128 | Two 64-bit bit matrices, one per 8-byte group |
| in_imm | input | 8 | Constant XORed into every result byte |
| in_inv_en | input | 1 | Enables the field inversion step |
| out_valid | output | 1 | Registered result is new this cycle |
| out_data | output | 128 | Sixteen registered result bytes |

## Verification
The checker watches, on every cycle, the reset values, the one-cycle delay of the valid flag, and that the result holds while no operation is presented. It also checks that a zero matrix yields only the constant, that the identity matrix with a zero constant returns the input unchanged, and that a zero byte with inversion enabled yields zero. The field inverse of every one of the 256 byte values, and the exact bit-mask encoding of the matrix, can only be shown by the bench's scenarios. So can the split of matrices between the two byte groups and the ordering of the three steps. The bench compares each lane against a model that finds inverses by exhaustive search.

// File: rtl/gf8_pkg.sv
package gf8_pkg;
  localparam int BYTE_W = 8;
  localparam int MAT_W  = BYTE_W * BYTE_W;
  localparam int PROD_W = 2 * BYTE_W - 1;
  localparam logic [BYTE_W:0] FIELD_POLY = 9'h11B;

  // Carry-less product followed by polynomial reduction from the top term down.
  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [PROD_W-1:0] prod;
    prod = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (b[i]) prod = prod ^ (PROD_W'(a) << i);
    for (int k = PROD_W - 1; k >= BYTE_W; k--)
      if (prod[k]) prod = prod ^ (PROD_W'(FIELD_POLY) << (k - BYTE_W));
    return prod[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/gf8_inv.sv
module gf8_inv
  import gf8_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  // x^254 = x^240 * x^12 * x^2 ; zero maps to zero naturally
  logic [BYTE_W-1:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252;

  always_comb begin
    p2   = gf_mul(x, x);
    p3   = gf_mul(p2, x);
    p6   = gf_mul(p3, p3);
    p12  = gf_mul(p6, p6);
    p15  = gf_mul(p12, p3);
    p30  = gf_mul(p15, p15);
    p60  = gf_mul(p30, p30);
    p120 = gf_mul(p60, p60);
    p240 = gf_mul(p120, p120);
    p252 = gf_mul(p240, p12);
    y    = gf_mul(p252, p2);
  end
endmodule

// File: rtl/gf8_affine.sv
module gf8_affine
  import gf8_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  input  logic [MAT_W-1:0]  mat,
  input  logic [BYTE_W-1:0] imm,
  output logic [BYTE_W-1:0] y
);
  logic [BYTE_W-1:0] prod;

  // Result bit i is the parity of x under mask byte (BYTE_W-1-i).
  for (genvar i = 0; i < BYTE_W; i++) begin : g_row
    assign prod[i] = ^(mat[(BYTE_W-1-i)*BYTE_W +: BYTE_W] & x);
  end

  assign y = prod ^ imm;
endmodule

// File: rtl/gf8_lane.sv
module gf8_lane
  import gf8_pkg::*;
(
  input  logic [BYTE_W-1:0] lane_in,
  input  logic [MAT_W-1:0]  lane_mat,
  input  logic [BYTE_W-1:0] lane_imm,
  input  logic              lane_inv_en,
  output logic [BYTE_W-1:0] lane_out
);
  logic [BYTE_W-1:0] inv_val;
  logic [BYTE_W-1:0] pre_val;

  gf8_inv u_inv (
    .x (lane_in),
    .y (inv_val)
  );

  assign pre_val = lane_inv_en ? inv_val : lane_in;

  gf8_affine u_aff (
    .x   (pre_val),
    .mat (lane_mat),
    .imm (lane_imm),
    .y   (lane_out)
  );
endmodule

// File: rtl/gf8_affine_unit.sv
module gf8_affine_unit
  import gf8_pkg::*;
#(
  parameter int NUM_LANES     = 16,
  parameter int LANES_PER_MAT = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [NUM_LANES*BYTE_W-1:0]   in_data,
  input  logic [(NUM_LANES/LANES_PER_MAT)*MAT_W-1:0] in_mat,
  input  logic [BYTE_W-1:0]             in_imm,
  input  logic                          in_inv_en,
  output logic                          out_valid,
  output logic [NUM_LANES*BYTE_W-1:0]   out_data
);
  localparam int DATA_W = NUM_LANES * BYTE_W;

  logic [DATA_W-1:0] lane_res;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int GRP = k / LANES_PER_MAT;
    gf8_lane u_lane (
      .lane_in     (in_data[k*BYTE_W +: BYTE_W]),
      .lane_mat    (in_mat[GRP*MAT_W +: MAT_W]),
      .lane_imm    (in_imm),
      .lane_inv_en (in_inv_en),
      .lane_out    (lane_res[k*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= lane_res;
    end
  end
endmodule

// File: rtl/gf8_affine_unit_chk.sv
module gf8_affine_unit_chk
  import gf8_pkg::*;
#(
  parameter int NUM_LANES     = 16,
  parameter int LANES_PER_MAT = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          in_valid,
  input logic [NUM_LANES*BYTE_W-1:0]   in_data,
  input logic [(NUM_LANES/LANES_PER_MAT)*MAT_W-1:0] in_mat,
  input logic [BYTE_W-1:0]             in_imm,
  input logic                          in_inv_en,
  input logic                          out_valid,
  input logic [NUM_LANES*BYTE_W-1:0]   out_data
);
  localparam int NGRP = NUM_LANES / LANES_PER_MAT;
  localparam logic [MAT_W-1:0] IDENT = 64'h0102040810204080;

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: state after a reset edge
  always @(negedge clk) begin
    if (rst_seen)
      assert_reset_clear_R1: assert (out_valid == 1'b0 && out_data == '0);
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R3: a zero matrix leaves only the constant in every lane
  assert_zero_matrix_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mat == '0) |=> out_data == {NUM_LANES{$past(in_imm)}});

  assert_zero_inverse_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_inv_en && in_data == '0 && in_imm == '0) |=> out_data == '0);

  assert_identity_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_inv_en && in_mat == {NGRP{IDENT}} && in_imm == '0)
      |=> out_data == $past(in_data));
endmodule

bind gf8_affine_unit gf8_affine_unit_chk #(
  .NUM_LANES     (NUM_LANES),
  .LANES_PER_MAT (LANES_PER_MAT)
) u_chk (.*);

// File: tb/gf8_affine_unit_test.sv
module gf8_affine_unit_test;
  localparam int LANES = 16;
  localparam logic [63:0] IDENT = 64'h0102040810204080;
  localparam logic [63:0] REVM  = 64'h8040201008040201;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic [127:0] in_mat = '0;
  logic [7:0]   in_imm = '0;
  logic         in_inv_en = 1'b0;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  gf8_affine_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_mat(in_mat), .in_imm(in_imm), .in_inv_en(in_inv_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, t;
    r = 8'h00; t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] x);
    if (x == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++)
      if (ref_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [7:0] ref_lane(input logic [7:0] x, input logic [63:0] m,
                                          input logic [7:0] imm, input logic inv);
    logic [7:0] v, r;
    v = inv ? ref_inv(x) : x;
    for (int i = 0; i < 8; i++) r[i] = ^(m[(7 - i) * 8 +: 8] & v);
    return r ^ imm;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // ---------------- check helpers ----------------
  task automatic check_bits(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_lane(input string req, input int lane, input logic [7:0] act,
                            input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane=%0d actual=%h expected=%h", req, lane, act, exp);
    end
  endtask

  // Present one operation and sample the registered result after the edge.
  task automatic apply(input logic [127:0] d, input logic [127:0] m,
                       input logic [7:0] imm, input logic inv);
    @(negedge clk);
    in_data = d; in_mat = m; in_imm = imm; in_inv_en = inv; in_valid = 1'b1;
    @(posedge clk);
    #2;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(input string req, input logic [127:0] d, input logic [127:0] m,
                         input logic [7:0] imm, input logic inv);
    apply(d, m, imm, inv);
    for (int k = 0; k < LANES; k++)
      check_lane(req, k, out_data[k*8 +: 8],
                 ref_lane(d[k*8 +: 8], m[(k / 8) * 64 +: 64], imm, inv));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check_bits("R1", {127'b0, out_valid}, 128'h0);
    check_bits("R1", out_data, 128'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_valid;
    @(negedge clk);
    in_data = 128'h11; in_mat = {2{IDENT}}; in_imm = 8'h00; in_inv_en = 1'b0; in_valid = 1'b1;
    @(posedge clk); #2;
    check_bits("R2", {127'b0, out_valid}, 128'h1);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #2;
    check_bits("R2", {127'b0, out_valid}, 128'h0);
  endtask

  task automatic t_identity;
    logic [127:0] d;
    d = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    apply(d, {2{IDENT}}, 8'h00, 1'b0);
    check_bits("R8", out_data, d);
  endtask

  task automatic t_inverse_all;
    for (int op = 0; op < 16; op++) begin
      logic [127:0] d, exp;
      for (int k = 0; k < LANES; k++) d[k*8 +: 8] = 8'(op * 16 + k);
      apply(d, {2{IDENT}}, 8'h00, 1'b1);
      for (int k = 0; k < LANES; k++) begin
        exp[k*8 +: 8] = ref_inv(d[k*8 +: 8]);
        check_lane("R8", k, out_data[k*8 +: 8], exp[k*8 +: 8]);
        if (d[k*8 +: 8] != 8'h00)
          check_lane("R4", k, ref_mul(out_data[k*8 +: 8], d[k*8 +: 8]), 8'h01);
      end
    end
  endtask

  task automatic t_zero;
    apply(128'h0, {2{REVM}}, 8'hA5, 1'b1);
    check_bits("R5", out_data, {16{8'hA5}});
  endtask

  task automatic t_reverse_rotate;
    logic [127:0] d, exp;
    logic [63:0] rot;
    d = 128'h8001_4002_2004_1008_C3A5_5A3C_F00F_0F7E;
    apply(d, {2{REVM}}, 8'h00, 1'b0);
    for (int k = 0; k < LANES; k++)
      for (int b = 0; b < 8; b++) exp[k*8 + b] = d[k*8 + 7 - b];
    check_bits("R10", out_data, exp);
    for (int i = 0; i < 8; i++) rot[(7 - i) * 8 +: 8] = 8'h01 << ((i + 7) % 8);
    apply(d, {2{rot}}, 8'h00, 1'b0);
    for (int k = 0; k < LANES; k++) exp[k*8 +: 8] = {d[k*8 +: 7], d[k*8 + 7]};
    check_bits("R10", out_data, exp);
  endtask

  task automatic t_mask_encoding;
    // one mask byte active at a time: only result bit (7 - m) sees the input
    for (int m = 0; m < 8; m++) begin
      logic [63:0] mm;
      logic [127:0] exp;
      mm = 64'hFF << (m * 8);
      apply({16{8'h01}}, {2{mm}}, 8'h00, 1'b0);
      exp = {16{8'h01 << (7 - m)}};
      check_bits("R6", out_data, exp);
    end
  endtask

  task automatic t_group_split;
    logic [127:0] d, exp;
    d = {16{8'h35}};
    apply(d, {REVM, IDENT}, 8'h00, 1'b0);
    exp = {{8{8'hAC}}, {8{8'h35}}};
    check_bits("R7", out_data, exp);
  endtask

  task automatic t_random;
    for (int n = 0; n < 24; n++) begin
      logic [127:0] d, m;
      logic [7:0] imm;
      for (int w = 0; w < 4; w++) begin seed = next_rand(seed); d[w*32 +: 32] = seed; end
      for (int w = 0; w < 4; w++) begin seed = next_rand(seed); m[w*32 +: 32] = seed; end
      seed = next_rand(seed); imm = seed[7:0];
      run_vec("R3", d, m, imm, seed[8]);
    end
  endtask

  task automatic t_hold;
    logic [127:0] held;
    apply(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, {2{IDENT}}, 8'h3C, 1'b1);
    held = out_data;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_data = ~in_data; in_imm = in_imm + 8'd7; in_inv_en = ~in_inv_en;
      @(posedge clk); #2;
      check_bits("R9", out_data, held);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_valid();
    t_identity();
    t_inverse_all();
    t_zero();
    t_reverse_rotate();
    t_mask_encoding();
    t_group_split();
    t_random();
    t_hold();
    finish_run();
  end
endmodule